// File: doc/BRIEF.md
# External bus wait-state controller

This block times accesses to an external memory space that is divided into eight areas. Each area has a mode bit and a 3-bit program-wait count, all held in three software-visible control registers. When a request arrives, the block looks up the area's settings and works out the length of the bus cycle. A fast area runs two states. A slow area runs three states plus its wait count. An access to on-chip memory or internal registers always runs two states.

The block drives a state index that a bus-cycle sequencer can decode, holds busy for the length of the access, and pulses done in the final state. The length is fixed when the request is accepted, so a register write made during an access only affects later accesses. Hardware reset and hardware standby return all three registers to their initial values and end any access in progress. Software standby keeps the register contents and holds off new requests.

Top module: `ext_wait_ctrl`

## Requirements
- R1: After reset the mode register (select 0) reads 0x00FF and both wait registers (select 1 = areas 7..4, select 2 = areas 3..0) read 0x7777; busy_o and done_o are low.
- R2: In the wait registers, bits 15, 11, 7 and 3 always read 0 and ignore writes. The mode register reads 0 in bits 15:8. Select 3 reads 0 and ignores writes.
- R3: Within a wait register, the highest area of the group sits in bits 14:12, the next in 10:8, the next in 6:4 and the lowest in 2:0.
- R4: An external access to an area whose mode bit (bit n for area n of the mode register) is 0 lasts exactly 2 states, whatever its wait count.
- R5: An external access to an area whose mode bit is 1 lasts exactly 3 + W states, where W is that area's 3-bit wait count.
- R6: An internal access (req_ext_i = 0) lasts exactly 2 states, whatever the mode bits and wait counts.
- R7: During an access of N states, busy_o is high for N consecutive cycles, state_idx_o counts 0 to N-1, and done_o is high only in the cycle where the index is N-1.
- R8: A request is accepted only while idle. Requests raised during an access are ignored and do not change its length.
- R9: A register write made during an access does not change that access's length. It takes effect from the next access.
- R10: While sw_stby_i is high, the register contents are kept and no new request is accepted.
- R11: hw_stby_i high at a clock edge ends any access at that edge and restores all three registers to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_stby_i | input | 1 | Hardware standby: restores the registers and ends any access |
| sw_stby_i | input | 1 | Software standby: keeps the registers and blocks new requests |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 2 | Register select: 0 = mode, 1 = wait areas 7..4, 2 = wait areas 3..0 |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for the selected register (combinational) |
| req_i | input | 1 | Access request |
| req_area_i | input | 3 | Area index of the request |
| req_ext_i | input | 1 | 1 = external space, 0 = internal |
| busy_o | output | 1 | An access is in progress |
| state_idx_o | output | 4 | Index of the current state within the access |
| done_o | output | 1 | High in the final state of an access |

## Verification
A request sampled at a clock edge makes busy_o high with state_idx_o at 0 after that same edge. The access then lasts N cycles, so done_o is due N-1 cycles after the accepting edge and busy_o falls one edge later. Read data is combinational: a write is visible right after the edge that performs it. The bench drives every input on the falling edge and samples on the falling edge. It counts busy cycles from the first falling edge after acceptance and records the cycle in which done_o appears, so every length and strobe position is compared against 2, 3 + W or the internal fixed value, cycle by cycle.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  localparam int AREAS      = 8;
  localparam int AREA_W     = $clog2(AREAS);
  localparam int WAIT_W     = 3;
  localparam int REG_W      = 16;
  localparam int PER_REG    = 4;
  localparam int BASE_FAST  = 2;
  localparam int BASE_SLOW  = 3;
  localparam int INT_STATES = 2;
  localparam int MAX_STATES = BASE_SLOW + (2**WAIT_W) - 1;
  localparam int CNT_W      = $clog2(MAX_STATES + 1);

  localparam logic [AREAS-1:0]  MODE_RST = '1;
  localparam logic [WAIT_W-1:0] WAIT_RST = '1;

  typedef enum logic [1:0] {
    SEL_MODE    = 2'd0,
    SEL_WAIT_HI = 2'd1,
    SEL_WAIT_LO = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  // bit offset of slot k (0 = lowest area of the group) inside a wait register
  function automatic int slot_lsb(int k);
    return (k / 2) * 8 + (k % 2) * 4;
  endfunction
endpackage

// File: rtl/ewc_regs.sv
module ewc_regs
  import ewc_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         init_i,
  input  logic                         we_i,
  input  logic [1:0]                   sel_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [REG_W-1:0]             rdata_o,
  output logic [AREAS-1:0]             mode_o,
  output logic [AREAS-1:0][WAIT_W-1:0] wait_o
);
  logic [AREAS-1:0]             mode_q;
  logic [AREAS-1:0][WAIT_W-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      for (int a = 0; a < AREAS; a++) wait_q[a] <= WAIT_RST;
    end else if (init_i) begin
      mode_q <= MODE_RST;
      for (int a = 0; a < AREAS; a++) wait_q[a] <= WAIT_RST;
    end else if (we_i) begin
      case (reg_sel_e'(sel_i))
        SEL_MODE: mode_q <= wdata_i[AREAS-1:0];
        SEL_WAIT_HI:
          for (int k = 0; k < PER_REG; k++)
            wait_q[PER_REG+k] <= wdata_i[slot_lsb(k) +: WAIT_W];
        SEL_WAIT_LO:
          for (int k = 0; k < PER_REG; k++)
            wait_q[k] <= wdata_i[slot_lsb(k) +: WAIT_W];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_sel_e'(sel_i))
      SEL_MODE: rdata_o[AREAS-1:0] = mode_q;
      SEL_WAIT_HI:
        for (int k = 0; k < PER_REG; k++)
          rdata_o[slot_lsb(k) +: WAIT_W] = wait_q[PER_REG+k];
      SEL_WAIT_LO:
        for (int k = 0; k < PER_REG; k++)
          rdata_o[slot_lsb(k) +: WAIT_W] = wait_q[k];
      default: ;
    endcase
  end

  assign mode_o = mode_q;
  assign wait_o = wait_q;
endmodule

// File: rtl/ewc_len.sv
module ewc_len
  import ewc_pkg::*;
(
  input  logic [AREAS-1:0]             mode_i,
  input  logic [AREAS-1:0][WAIT_W-1:0] wait_i,
  input  logic [AREA_W-1:0]            area_i,
  input  logic                         ext_i,
  output logic [CNT_W-1:0]             len_o
);
  always_comb begin
    if (!ext_i)              len_o = CNT_W'(INT_STATES);
    else if (mode_i[area_i]) len_o = CNT_W'(BASE_SLOW) + CNT_W'(wait_i[area_i]);
    else                     len_o = CNT_W'(BASE_FAST);
  end
endmodule

// File: rtl/ewc_seq.sv
module ewc_seq
  import ewc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             done_o
);
  logic             busy_q;
  logic [CNT_W-1:0] idx_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      last_q <= len_i - CNT_W'(1);
    end else if (busy_q) begin
      if (idx_q == last_q) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + CNT_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = busy_q && (idx_q == last_q);
endmodule

// File: rtl/ext_wait_ctrl.sv
module ext_wait_ctrl
  import ewc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_stby_i,
  input  logic              sw_stby_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              req_i,
  input  logic [AREA_W-1:0] req_area_i,
  input  logic              req_ext_i,
  output logic              busy_o,
  output logic [CNT_W-1:0]  state_idx_o,
  output logic              done_o
);
  logic [AREAS-1:0]             mode;
  logic [AREAS-1:0][WAIT_W-1:0] waits;
  logic [CNT_W-1:0]             len;
  logic                         start;

  assign start = req_i && !busy_o && !sw_stby_i && !hw_stby_i;

  ewc_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (hw_stby_i),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .mode_o  (mode),
    .wait_o  (waits)
  );

  ewc_len u_len (
    .mode_i (mode),
    .wait_i (waits),
    .area_i (req_area_i),
    .ext_i  (req_ext_i),
    .len_o  (len)
  );

  ewc_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (hw_stby_i),
    .start_i (start),
    .len_i   (len),
    .busy_o  (busy_o),
    .idx_o   (state_idx_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/ewc_chk.sv
module ewc_chk
  import ewc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hw_stby_i,
  input logic              sw_stby_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              req_i,
  input logic [AREA_W-1:0] req_area_i,
  input logic              req_ext_i,
  input logic              busy_o,
  input logic [CNT_W-1:0]  state_idx_o,
  input logic              done_o
);
  logic accept, ext_q;
  assign accept = req_i && !busy_o && !sw_stby_i && !hw_stby_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ext_q <= 1'b0;
    else if (accept) ext_q <= req_ext_i;
  end

  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R7
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !accept |=> !busy_o); // R7
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && !hw_stby_i |=> busy_o && state_idx_o == $past(state_idx_o) + 1'b1); // R7
  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o && state_idx_o == '0); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && !hw_stby_i |=> state_idx_o != '0); // R8
  AST_MIN_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && state_idx_o == '0 |-> !done_o); // R4
  AST_INT_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ext_q |-> done_o == (state_idx_o == CNT_W'(1))); // R6
  AST_MAX_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> state_idx_o <= CNT_W'(MAX_STATES - 1)); // R5
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i != 2'd0 |-> (reg_rdata_o & 16'h8888) == '0); // R2
  AST_MODE_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i == 2'd0 |-> reg_rdata_o[15:8] == '0); // R2
  AST_SW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_stby_i && !busy_o |=> !busy_o); // R10
  AST_HW_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> !busy_o); // R11
endmodule

bind ext_wait_ctrl ewc_chk u_chk (.*);

// File: tb/ext_wait_ctrl_tb.sv
module ext_wait_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hw_stby_i = 1'b0, sw_stby_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        req_i = 1'b0;
  logic [2:0]  req_area_i = '0;
  logic        req_ext_i = 1'b0;
  logic        busy_o, done_o;
  logic [3:0]  state_idx_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;

  ext_wait_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    reg_sel_i = sel;
    #1;
    chk(reg_rdata_o == exp, tag, reg_rdata_o, exp);
  endtask

  function automatic logic [15:0] pack(input int w3, input int w2, input int w1, input int w0);
    int w[4];
    logic [15:0] r = '0;
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    for (int k = 0; k < 4; k++) r |= 16'((w[k] & 7) << ((k / 2) * 8 + (k % 2) * 4));
    return r;
  endfunction

  // from first falling edge after acceptance: count busy cycles and locate done
  task automatic measure(output int n, output int done_at, output bit idx_ok);
    n = 0; done_at = -1; idx_ok = 1'b1;
    while (busy_o && n < 20) begin
      if (done_o) begin
        if (done_at >= 0) idx_ok = 1'b0;
        done_at = n;
      end
      if (int'(state_idx_o) != n) idx_ok = 1'b0;
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic run_acc(input int area, input bit ext, input int exp, input string tag);
    int n, d;
    bit ok;
    @(negedge clk_i);
    req_i = 1'b1; req_area_i = 3'(area); req_ext_i = ext;
    @(negedge clk_i);
    req_i = 1'b0;
    measure(n, d, ok);
    chk(n == exp, tag, n, exp);
    chk(d == exp - 1 && ok, {tag, " R7 done/index"}, d, exp - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, d;
    bit ok;
    int w[8];
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset values
    rd(2'd0, 16'h00FF, "R1 mode reset");
    rd(2'd1, 16'h7777, "R1 wait hi reset");
    rd(2'd2, 16'h7777, "R1 wait lo reset");
    chk(!busy_o && !done_o, "R1 idle after reset", {busy_o, done_o}, 0);

    // R2 reserved bits and upper mode byte
    wr(2'd1, 16'hFFFF); rd(2'd1, 16'h7777, "R2 wait hi reserved");
    wr(2'd2, 16'h8888); rd(2'd2, 16'h0000, "R2 wait lo reserved");
    wr(2'd0, 16'hFF5A); rd(2'd0, 16'h005A, "R2 mode upper byte");
    wr(2'd3, 16'hFFFF);
    rd(2'd3, 16'h0000, "R2 select 3 reads zero");
    rd(2'd0, 16'h005A, "R2 select 3 write ignored mode");
    rd(2'd1, 16'h7777, "R2 select 3 write ignored hi");
    rd(2'd2, 16'h0000, "R2 select 3 write ignored lo");

    // R3/R4/R5 sweep: every area, both mode settings, every wait count
    for (int rnd = 0; rnd < 8; rnd++) begin
      for (int a = 0; a < 8; a++) w[a] = (rnd + a) % 8;
      wr(2'd1, pack(w[7], w[6], w[5], w[4]) | 16'h8888);
      wr(2'd2, pack(w[3], w[2], w[1], w[0]) | 16'h8888);
      rd(2'd1, pack(w[7], w[6], w[5], w[4]), "R3 wait hi layout");
      rd(2'd2, pack(w[3], w[2], w[1], w[0]), "R3 wait lo layout");
      wr(2'd0, 16'h0000);
      for (int a = 0; a < 8; a++) run_acc(a, 1'b1, 2, "R4 fast area");
      wr(2'd0, 16'h00FF);
      for (int a = 0; a < 8; a++) run_acc(a, 1'b1, 3 + w[a], "R5 R3 slow area");
      wr(2'd0, 16'h00A5);
      for (int a = 0; a < 8; a++)
        run_acc(a, 1'b1, ((8'hA5 >> a) & 1) ? 3 + w[a] : 2, "R4 R5 mixed modes");
    end

    // R6 internal bypass
    wr(2'd1, 16'h7777); wr(2'd2, 16'h7777); wr(2'd0, 16'h00FF);
    for (int a = 0; a < 8; a++) run_acc(a, 1'b0, 2, "R6 internal slow cfg");
    wr(2'd0, 16'h0000);
    run_acc(5, 1'b0, 2, "R6 internal fast cfg");

    // R8 requests during an access are ignored
    wr(2'd0, 16'h00FF);
    @(negedge clk_i);
    req_i = 1'b1; req_area_i = 3'd7; req_ext_i = 1'b1;
    @(negedge clk_i);
    req_area_i = 3'd0; req_ext_i = 1'b0;
    n = 0; d = -1;
    while (busy_o && n < 20) begin
      if (done_o) d = n;
      if (n == 4) req_i = 1'b0;
      n++;
      @(negedge clk_i);
    end
    chk(n == 10, "R8 length kept under request", n, 10);
    chk(d == 9, "R8 done position", d, 9);
    @(negedge clk_i);
    chk(!busy_o, "R8 no late start", busy_o, 0);

    // R9 write during access affects next access only
    @(negedge clk_i);
    req_i = 1'b1; req_area_i = 3'd3; req_ext_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    reg_we_i = 1'b1; reg_sel_i = 2'd0; reg_wdata_i = 16'h0000;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    measure(n, d, ok);
    chk(n + 1 == 10, "R9 current access kept", n + 1, 10);
    run_acc(3, 1'b1, 2, "R9 next access uses new mode");

    // R10 software standby
    wr(2'd0, 16'h003C); wr(2'd2, pack(1, 2, 3, 4));
    @(negedge clk_i);
    sw_stby_i = 1'b1; req_i = 1'b1; req_area_i = 3'd2; req_ext_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R10 request held off", busy_o, 0);
    req_i = 1'b0;
    @(negedge clk_i);
    sw_stby_i = 1'b0;
    rd(2'd0, 16'h003C, "R10 mode kept");
    rd(2'd2, pack(1, 2, 3, 4), "R10 wait kept");
    run_acc(2, 1'b1, 5, "R10 access after standby");

    // R11 hardware standby aborts and restores
    run_acc(0, 1'b1, 2, "R4 area 0 fast");
    @(negedge clk_i);
    req_i = 1'b1; req_area_i = 3'd5; req_ext_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    @(negedge clk_i);
    hw_stby_i = 1'b1;
    @(negedge clk_i);
    hw_stby_i = 1'b0;
    chk(!busy_o && !done_o, "R11 access ended", {busy_o, done_o}, 0);
    rd(2'd0, 16'h00FF, "R11 mode restored");
    rd(2'd1, 16'h7777, "R11 wait hi restored");
    rd(2'd2, 16'h7777, "R11 wait lo restored");
    run_acc(1, 1'b1, 10, "R11 access after standby");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule